// File: doc/BRIEF.md
# Processor-Side Six-Bit Port with Direction Control

This block is a small parallel port that sits at the very bottom of the processor's address space. It occupies two byte addresses. Address 0 holds a direction register. Address 1 holds a data register. Each of the six port bits can be set to drive a pin or to sense one. The three lowest bits drive the memory-banking selects that decide which ROM, RAM or I/O a given region shows. Bit 0 selects the low-ROM bank, bit 1 the high-ROM bank, and bit 2 chooses between the character ROM and I/O. The upper three bits serve a tape interface: bit 3 is the write line, bit 4 senses the play switch (it reads 0 while pressed), and bit 5 runs the motor (0 turns it on).

The port decodes the bus itself and flags when it owns an access, so that the rest of the system can ignore addresses 0 and 1. A pin set as an input reaches downstream logic as a pulled-up 1. Straight after reset every bit is an input, so the banking selects all read 1 and the default memory map is active. Software normally loads 47 (binary 101111) into the direction register and keeps bits 0 to 2 of the data register at 1.

Top module: `cpu_port`

## Requirements
- R1: After reset the direction and data registers are both zero, `pin_dir` is 000000 and `pin_out` is 111111.
- R2: A write to address 0 with `bus_we` high loads the low six bits of `bus_wdata` into the direction register at the next rising clock edge. A read at address 0 returns that register. In the direction register a 1 makes the bit an output.
- R3: A write to address 1 with `bus_we` high loads the low six bits of `bus_wdata` into the data register at the next rising clock edge. Each bit whose direction bit is 1 then drives that value on `pin_out`.
- R4: Each bit whose direction bit is 0 shows 1 on `pin_out`, whatever value the data register holds.
- R5: A read at address 1 returns `pin_in` for input bits and the data register for output bits. With direction 47, bit 4 (tape sense) follows `pin_in[4]`.
- R6: Bits 7 and 6 of `bus_rdata` are always 0, and the same bits of `bus_wdata` are discarded.
- R7: `bus_hit` is 1 only when `bus_addr` is 0 or 1. At every other address `bus_rdata` is 0 and a write changes neither register.
- R8: While `bus_we` is low, neither register changes, whatever the address and data.
- R9: Reset given during operation returns the port to the state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; writes commit on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data; 0 when the port does not own the access |
| bus_hit | output | 1 | Set when the address is 0 or 1 |
| pin_in | input | 6 | Sensed pin levels |
| pin_out | output | 6 | Effective pin levels (output bits carry data, input bits carry 1) |
| pin_dir | output | 6 | Current direction register (1 means output) |

## Verification
The hardest case to reach from the ports is a read at address 1 where the direction bits mix inputs and outputs, and the pin levels differ from the latched data on both kinds of bit. Only that case shows whether each bit is taken from the correct source. The stimulus table sets a mixed direction, writes data that conflicts with the applied pins, and then reads. After that it clears the direction while leaving non-zero data in place, which shows that input bits are pulled up on `pin_out`. Writes to address 0x0100 and to address 2, and an address-1 access with the strobe low, are each followed by a read-back. These show that a near-miss access leaves the registers untouched.

// File: rtl/cpu_port_pkg.sv
package cpu_port_pkg;
  localparam int PORT_W = 6;

  // Value seen by a reader of the data address: sensed level on input bits, latch on output bits
  function automatic logic [PORT_W-1:0] merge_read(input logic [PORT_W-1:0] dir,
                                                   input logic [PORT_W-1:0] dat,
                                                   input logic [PORT_W-1:0] pins);
    return (dat & dir) | (pins & ~dir);
  endfunction

  // Level presented downstream: input bits are pulled high
  function automatic logic [PORT_W-1:0] drive_level(input logic [PORT_W-1:0] dir,
                                                    input logic [PORT_W-1:0] dat);
    return (dat & dir) | ~dir;
  endfunction
endpackage

// File: rtl/cpu_port_decode.sv
module cpu_port_decode #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              hit,
  output logic              sel_dir,
  output logic              sel_dat,
  output logic              wr_dir,
  output logic              wr_dat
);
  assign hit     = (addr[ADDR_W-1:1] == '0);
  assign sel_dir = hit & ~addr[0];
  assign sel_dat = hit &  addr[0];
  assign wr_dir  = sel_dir & we;
  assign wr_dat  = sel_dat & we;
endmodule

// File: rtl/cpu_port_reg.sv
module cpu_port_reg #(
  parameter int              W   = 6,
  parameter logic [W-1:0]    RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST;
    else if (wr) q <= d;
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q));
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (q == $past(d)));
endmodule

// File: rtl/cpu_port_rdmux.sv
module cpu_port_rdmux #(
  parameter int DATA_W = 8,
  parameter int PORT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_dir,
  input  logic              sel_dat,
  input  logic [PORT_W-1:0] dir,
  input  logic [PORT_W-1:0] dat_view,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - PORT_W;

  always_comb begin
    rdata = '0;
    if (sel_dir)      rdata = {{PAD_W{1'b0}}, dir};
    else if (sel_dat) rdata = {{PAD_W{1'b0}}, dat_view};
  end

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_dir || sel_dat) |-> (rdata == '0));
  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:PORT_W] == '0);
endmodule

// File: rtl/cpu_port.sv
module cpu_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_hit,
  input  logic [5:0]        pin_in,
  output logic [5:0]        pin_out,
  output logic [5:0]        pin_dir
);
  import cpu_port_pkg::*;

  logic sel_dir, sel_dat, wr_dir, wr_dat;
  logic [PORT_W-1:0] dir_q, dat_q, dat_view;

  cpu_port_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .we(bus_we), .hit(bus_hit),
    .sel_dir(sel_dir), .sel_dat(sel_dat), .wr_dir(wr_dir), .wr_dat(wr_dat));

  cpu_port_reg #(.W(PORT_W), .RST('0)) u_dir (
    .clk(clk), .rst_n(rst_n), .wr(wr_dir), .d(bus_wdata[PORT_W-1:0]), .q(dir_q));

  cpu_port_reg #(.W(PORT_W), .RST('0)) u_dat (
    .clk(clk), .rst_n(rst_n), .wr(wr_dat), .d(bus_wdata[PORT_W-1:0]), .q(dat_q));

  assign dat_view = merge_read(dir_q, dat_q, pin_in);
  assign pin_out  = drive_level(dir_q, dat_q);
  assign pin_dir  = dir_q;

  cpu_port_rdmux #(.DATA_W(DATA_W), .PORT_W(PORT_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .sel_dir(sel_dir), .sel_dat(sel_dat),
    .dir(dir_q), .dat_view(dat_view), .rdata(bus_rdata));

  assert_pullup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (~pin_dir & ~pin_out) == '0);
  assert_sense_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_dat && !pin_dir[4]) |-> (bus_rdata[4] == pin_in[4]));
  assert_nohit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_hit && bus_we) |=> ($stable(pin_dir) && $stable(pin_out)));
endmodule

// File: tb/tb_cpu_port.sv
module tb_cpu_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we;
  logic [7:0]  bus_rdata;
  logic        bus_hit;
  logic [5:0]  pin_in;
  logic [5:0]  pin_out;
  logic [5:0]  pin_dir;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cpu_port dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .bus_hit(bus_hit), .pin_in(pin_in),
    .pin_out(pin_out), .pin_dir(pin_dir));

  // {req, we, addr, wdata, pin_in, expected rdata, expected pin_out}; expectations describe
  // the state before the edge that commits the row's write
  localparam int NV = 15;
  localparam logic [48:0] VEC [NV] = '{
    {4'd5, 1'b0, 16'h0001, 8'h00, 6'h2A, 8'h2A, 6'h3F},  // R5 all inputs: pins read back
    {4'd2, 1'b1, 16'h0000, 8'hEF, 6'h00, 8'h00, 6'h3F},  // R2 write 47 (+bits 7:6, R6)
    {4'd6, 1'b0, 16'h0000, 8'h00, 6'h00, 8'h2F, 6'h10},  // R6 upper bits dropped, reads 47
    {4'd3, 1'b1, 16'h0001, 8'hC7, 6'h3F, 8'h10, 6'h10},  // R3 data write
    {4'd3, 1'b0, 16'h0001, 8'h00, 6'h00, 8'h07, 6'h17},  // R3 outputs driven
    {4'd7, 1'b1, 16'h0002, 8'hFF, 6'h10, 8'h00, 6'h17},  // R7 address 2 not ours
    {4'd7, 1'b0, 16'h0001, 8'h00, 6'h10, 8'h17, 6'h17},  // R7 data untouched
    {4'd7, 1'b1, 16'h0100, 8'h00, 6'h10, 8'h00, 6'h17},  // R7 high-byte alias not ours
    {4'd7, 1'b0, 16'h0000, 8'h00, 6'h10, 8'h2F, 6'h17},  // R7 direction untouched
    {4'd8, 1'b0, 16'h0001, 8'h00, 6'h00, 8'h07, 6'h17},  // R8 strobe low
    {4'd8, 1'b0, 16'h0001, 8'h00, 6'h00, 8'h07, 6'h17},  // R8 no change
    {4'd3, 1'b1, 16'h0001, 8'h28, 6'h10, 8'h17, 6'h17},  // R3 new data
    {4'd5, 1'b0, 16'h0001, 8'h00, 6'h10, 8'h38, 6'h38},  // R5 mixed read, tape sense high
    {4'd2, 1'b1, 16'h0000, 8'h00, 6'h10, 8'h2F, 6'h38},  // R2 back to inputs
    {4'd4, 1'b0, 16'h0001, 8'h00, 6'h05, 8'h05, 6'h3F}   // R4 pulled up despite data
  };

  task automatic check(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [15:0] a, input logic [7:0] d,
                       input logic [5:0] p);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; pin_in = p;
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 16'h0; bus_wdata = 8'h0; pin_in = 6'h3F;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    drive(1'b0, 16'h0000, 8'h00, 6'h00);
    #1;
    check("R1", "dir read", bus_rdata, 8'h00);
    check("R1", "pin_dir", {2'b0, pin_dir}, 8'h00);
    check("R1", "pin_out", {2'b0, pin_out}, 8'h3F);
    check("R7", "hit at 0", {7'b0, bus_hit}, 8'h01);
    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d", v[48:45]);
      drive(v[44], v[43:28], v[27:20], v[19:14]);
      #1;
      check(tag, $sformatf("row %0d rdata", i), bus_rdata, v[13:6]);
      check(tag, $sformatf("row %0d pin_out", i), {2'b0, pin_out}, {2'b0, v[5:0]});
    end
    // R7 hit flag on a far address
    drive(1'b0, 16'hFFFF, 8'h00, 6'h00);
    #1;
    check("R7", "hit at FFFF", {7'b0, bus_hit}, 8'h00);
    // R9 reset during operation
    drive(1'b1, 16'h0000, 8'h3F, 6'h00);
    drive(1'b1, 16'h0001, 8'h15, 6'h00);
    drive(1'b0, 16'h0001, 8'h00, 6'h00);
    #1;
    check("R5", "all outputs read latch", bus_rdata, 8'h15);
    check("R2", "pin_dir after write", {2'b0, pin_dir}, 8'h3F);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R9", "data read after reset", bus_rdata, 8'h00);
    check("R9", "pin_dir after reset", {2'b0, pin_dir}, 8'h00);
    check("R9", "pin_out after reset", {2'b0, pin_out}, 8'h3F);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule